// File: doc/BRIEF.md
# Debug Trigger Chain Resolver

This block turns per-trigger match results into trap decisions for the instructions that reach it. Ten triggers are grouped as five pairs, where pair p holds triggers 2p and 2p+1. Each trigger has an enable bit, a timing bit and a precomputed match bit. A chain bit per pair can require both members of the pair to match on the same instruction before either may fire. Four match bits come from the fetch side and six from the memory side. The block places them on trigger slots according to the kind of each pair.

A trigger with timing 0 requests a trap before the matching instruction. A trigger with timing 1 requests a trap after it. That request is held pending and delivered with the next valid instruction. A pipeline flush discards the pending request. Every decision is registered and appears one cycle after the instruction strobe. Along with the decision, the block gives a one-hot record of the trigger that caused it.

Top module: `trig_chain_resolver`

## Requirements
- R1: Pair kinds in order are fetch/fetch, store/store, load/load, fetch/store, fetch/load. Fetch match bits 0..3 drive triggers 0, 1, 6, 8. Memory match bits 0..5 drive triggers 2, 3, 4, 5, 7, 9.
- R2: An unchained trigger fires exactly when its enable and match bits are both set, with its own timing. A disabled trigger never fires.
- R3: In a chained pair, neither member fires unless both are enabled and matching on the same instruction. When both fire, the record names the even member.
- R4: In a chained pair whose two timing bits differ, the pair never fires, even when both members match.
- R5: The chain bit of pair 1 (store/store) is ignored, so each of its triggers acts alone.
- R6: A timing-0 fire on a valid, unflushed instruction raises trap_before in the following cycle.
- R7: A timing-1 fire sets a pending trap. The next valid, unflushed instruction raises trap_after, with the record naming the trigger that set it. The pending trap then clears unless that instruction sets it again.
- R8: A flush clears the pending trap and its record. The flushed instruction raises no trap output in the following cycle.
- R9: When a timing-0 fire meets a pending trap on the same instruction, only trap_before is raised. The record names the timing-0 source, and the pending trap is consumed.
- R10: `fired` is one-hot and names the lowest-index trigger of the delivered cause. It is all zero whenever neither trap output is high.
- R11: After reset, all outputs are low and no trap is pending.
- R12: Outputs are pulses for one cycle after the strobe and are low in cycles that follow no valid instruction. A pending trap survives any number of cycles without a valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| flush | input | 1 | Pipeline flush; squashes the instruction and the pending trap |
| fetch_hit | input | 4 | Match bits from the fetch-side comparators |
| mem_hit | input | 6 | Match bits from the memory-side comparators |
| trig_timing | input | 10 | Per-trigger timing: 0 trap before, 1 trap after |
| trig_enable | input | 10 | Per-trigger enable |
| pair_chain | input | 5 | Per-pair chain request |
| trap_before | output | 1 | Trap before the instruction of the previous cycle |
| trap_after | output | 1 | Delivery of a pending trap-after |
| fired | output | 10 | One-hot record of the causing trigger |

## Verification
Directed patterns put a single match on each source bit, so that a slot mapping error appears as a wrong record bit. Chained pairs are driven with one member matching, with both matching, and with mismatched timing, which separates correct chain gating from plain OR behaviour. The store/store pair is driven with its chain bit set and one match, which exposes a design that honours that chain bit. Sequences of timing-1 fires followed by idle cycles, by flushes and by coincident timing-0 fires test the pending register. Random stimulus then mixes every input against a bench model.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int NUM_PAIRS = 5;
  localparam int NUM_TRIG  = 2 * NUM_PAIRS;
  localparam int NUM_FETCH = 4;
  localparam int NUM_MEM   = NUM_TRIG - NUM_FETCH;

  typedef enum logic [2:0] {
    KIND_FF, KIND_SS, KIND_LL, KIND_FS, KIND_FL
  } pair_kind_e;

  typedef enum logic {SRC_FETCH, SRC_MEM} src_e;

  function automatic pair_kind_e kind_of_pair(input int p);
    case (p)
      0:       return KIND_FF;
      1:       return KIND_SS;
      2:       return KIND_LL;
      3:       return KIND_FS;
      default: return KIND_FL;
    endcase
  endfunction

  // Source side feeding trigger t, derived from its pair kind
  function automatic src_e src_of_trig(input int t);
    pair_kind_e k;
    k = kind_of_pair(t / 2);
    case (k)
      KIND_FF:          return SRC_FETCH;
      KIND_SS, KIND_LL: return SRC_MEM;
      default:          return (t % 2 == 0) ? SRC_FETCH : SRC_MEM;
    endcase
  endfunction

  // Bit position of trigger t within its source vector
  function automatic int src_pos(input int t);
    int n;
    n = 0;
    for (int j = 0; j < t; j++)
      if (src_of_trig(j) == src_of_trig(t)) n++;
    return n;
  endfunction
endpackage

// File: rtl/trig_src_map.sv
module trig_src_map
  import trig_pkg::*;
(
  input  logic [NUM_FETCH-1:0] fetch_hit,
  input  logic [NUM_MEM-1:0]   mem_hit,
  output logic [NUM_TRIG-1:0]  trig_hit
);
  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_slot
    localparam int POS = src_pos(t);
    if (src_of_trig(t) == SRC_FETCH) begin : g_fetch
      assign trig_hit[t] = fetch_hit[POS];
    end else begin : g_mem
      assign trig_hit[t] = mem_hit[POS];
    end
  end
endmodule

// File: rtl/trig_pair_eval.sv
module trig_pair_eval #(
  parameter bit CHAIN_OK = 1'b1
) (
  input  logic [1:0] hit,
  input  logic [1:0] enable,
  input  logic [1:0] timing,
  input  logic       chain_req,
  output logic [1:0] fire_now,
  output logic [1:0] fire_late
);
  localparam logic ALLOW = CHAIN_OK;

  logic       chained;
  logic [1:0] armed;
  logic       both_ok;
  logic [1:0] fire;

  assign chained = chain_req & ALLOW;
  assign armed   = hit & enable;
  assign both_ok = armed[0] & armed[1] & (timing[0] == timing[1]);

  always_comb begin
    if (chained) fire = {2{both_ok}};
    else         fire = armed;
  end

  assign fire_now  = fire & ~timing;
  assign fire_late = fire &  timing;
endmodule

// File: rtl/trig_first_sel.sv
module trig_first_sel #(
  parameter int W = 10
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] onehot,
  output logic         any
);
  assign onehot = vec & (~vec + {{(W-1){1'b0}}, 1'b1});
  assign any    = |vec;
endmodule

// File: rtl/trig_chain_resolver.sv
module trig_chain_resolver
  import trig_pkg::*;
#(
  parameter int NO_CHAIN_PAIR = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic                 flush,
  input  logic [NUM_FETCH-1:0] fetch_hit,
  input  logic [NUM_MEM-1:0]   mem_hit,
  input  logic [NUM_TRIG-1:0]  trig_timing,
  input  logic [NUM_TRIG-1:0]  trig_enable,
  input  logic [NUM_PAIRS-1:0] pair_chain,
  output logic                 trap_before,
  output logic                 trap_after,
  output logic [NUM_TRIG-1:0]  fired
);
  logic [NUM_TRIG-1:0] trig_hit;
  logic [NUM_TRIG-1:0] now_vec, late_vec;
  logic [NUM_TRIG-1:0] now_first, late_first;
  logic                now_any, late_any;

  trig_src_map u_map (
    .fetch_hit (fetch_hit),
    .mem_hit   (mem_hit),
    .trig_hit  (trig_hit)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    trig_pair_eval #(.CHAIN_OK(p != NO_CHAIN_PAIR)) u_pair (
      .hit       (trig_hit[2*p+1:2*p]),
      .enable    (trig_enable[2*p+1:2*p]),
      .timing    (trig_timing[2*p+1:2*p]),
      .chain_req (pair_chain[p]),
      .fire_now  (now_vec[2*p+1:2*p]),
      .fire_late (late_vec[2*p+1:2*p])
    );
  end

  trig_first_sel #(.W(NUM_TRIG)) u_sel_now (
    .vec (now_vec), .onehot (now_first), .any (now_any)
  );
  trig_first_sel #(.W(NUM_TRIG)) u_sel_late (
    .vec (late_vec), .onehot (late_first), .any (late_any)
  );

  logic                pend_q, pend_d;
  logic [NUM_TRIG-1:0] pend_rec_q, pend_rec_d;
  logic                pend_en;
  logic                tb_d, ta_d;
  logic [NUM_TRIG-1:0] rec_d;
  logic                take;

  assign take    = instr_valid & ~flush;
  assign pend_en = instr_valid | flush;

  always_comb begin
    tb_d  = take & now_any;
    ta_d  = take & pend_q & ~now_any;
    if (tb_d)      rec_d = now_first;
    else if (ta_d) rec_d = pend_rec_q;
    else           rec_d = '0;

    if (flush) begin
      pend_d     = 1'b0;
      pend_rec_d = '0;
    end else begin
      pend_d     = late_any;
      pend_rec_d = late_first;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_rec_q <= '0;
    end else if (pend_en) begin
      pend_q     <= pend_d;
      pend_rec_q <= pend_rec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_before <= 1'b0;
      trap_after  <= 1'b0;
      fired       <= '0;
    end else begin
      trap_before <= tb_d;
      trap_after  <= ta_d;
      fired       <= rec_d;
    end
  end
endmodule

// File: rtl/trig_chain_resolver_chk.sv
module trig_chain_resolver_chk
  import trig_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                instr_valid,
  input logic                flush,
  input logic                trap_before,
  input logic                trap_after,
  input logic [NUM_TRIG-1:0] fired
);
  // R9: a single instruction never raises both traps
  assert_single_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_before && trap_after));

  // R10: the record is one-hot or empty
  assert_rec_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fired));

  // R10: a record is present exactly while a trap is raised
  assert_rec_matches_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((fired != '0) == (trap_before || trap_after)));

  // R12: a trap only follows a valid unflushed instruction
  assert_trap_after_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_before || trap_after) |-> $past(instr_valid && !flush));

  // R8: a flushed instruction yields no trap output
  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !(trap_before || trap_after));
endmodule

bind trig_chain_resolver trig_chain_resolver_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .flush       (flush),
  .trap_before (trap_before),
  .trap_after  (trap_after),
  .fired       (fired)
);

// File: tb/trig_chain_resolver_tb_top.sv
`timescale 1ns/1ps
module trig_chain_resolver_tb_top;
  logic       clk;
  logic       rst_n;
  logic       instr_valid, flush;
  logic [3:0] fetch_hit;
  logic [5:0] mem_hit;
  logic [9:0] trig_timing, trig_enable;
  logic [4:0] pair_chain;
  logic       trap_before, trap_after;
  logic [9:0] fired;

  int checks = 0;
  int fails  = 0;

  logic       m_pend;
  logic [9:0] m_prec;

  trig_chain_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .flush(flush),
    .fetch_hit(fetch_hit), .mem_hit(mem_hit), .trig_timing(trig_timing),
    .trig_enable(trig_enable), .pair_chain(pair_chain),
    .trap_before(trap_before), .trap_after(trap_after), .fired(fired)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [9:0] lowest(input logic [9:0] v);
    for (int i = 0; i < 10; i++) if (v[i]) return 10'(1) << i;
    return '0;
  endfunction

  // Returns {late, now} per the requirements (R1..R5)
  function automatic logic [19:0] model_fire(input logic [3:0] fh, input logic [5:0] mh,
      input logic [9:0] tm, input logic [4:0] ch, input logic [9:0] en);
    logic [9:0] hit, act, fire;
    hit = '0;
    hit[0] = fh[0]; hit[1] = fh[1]; hit[6] = fh[2]; hit[8] = fh[3];
    hit[2] = mh[0]; hit[3] = mh[1]; hit[4] = mh[2]; hit[5] = mh[3];
    hit[7] = mh[4]; hit[9] = mh[5];
    act  = hit & en;
    fire = '0;
    for (int p = 0; p < 5; p++) begin
      if (ch[p] && p != 1) begin
        if (act[2*p] && act[2*p+1] && tm[2*p] == tm[2*p+1]) begin
          fire[2*p] = 1'b1; fire[2*p+1] = 1'b1;
        end
      end else begin
        fire[2*p] = act[2*p]; fire[2*p+1] = act[2*p+1];
      end
    end
    return {fire & tm, fire & ~tm};
  endfunction

  task automatic check(input string tag, input string what, input logic [9:0] act,
                       input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic f, input logic [3:0] fh,
                      input logic [5:0] mh, input logic [9:0] tm, input logic [4:0] ch,
                      input logic [9:0] en, input string tag);
    logic [19:0] mf;
    logic [9:0]  nowv, latev, erec;
    logic        take, etb, eta;
    @(negedge clk);
    instr_valid = v; flush = f; fetch_hit = fh; mem_hit = mh;
    trig_timing = tm; pair_chain = ch; trig_enable = en;
    mf    = model_fire(fh, mh, tm, ch, en);
    nowv  = mf[9:0];
    latev = mf[19:10];
    take  = v && !f;
    etb   = take && (nowv != 0);
    eta   = take && m_pend && (nowv == 0);
    erec  = etb ? lowest(nowv) : (eta ? m_prec : '0);
    @(posedge clk);
    #2;
    check(tag, "trap_before", 10'(trap_before), 10'(etb));
    check(tag, "trap_after",  10'(trap_after),  10'(eta));
    check(tag, "fired",       fired,            erec);
    if (f) begin
      m_pend = 1'b0; m_prec = '0;
    end else if (v) begin
      m_pend = (latev != 0); m_prec = lowest(latev);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0] all_en;
    all_en = '1;
    m_pend = 1'b0; m_prec = '0;
    rst_n = 1'b0; instr_valid = 0; flush = 0; fetch_hit = 0; mem_hit = 0;
    trig_timing = 0; trig_enable = 0; pair_chain = 0;
    repeat (3) @(posedge clk);
    #2;
    // R11: reset state
    check("R11", "trap_before", 10'(trap_before), 10'(0));
    check("R11", "trap_after",  10'(trap_after),  10'(0));
    check("R11", "fired",       fired,            10'(0));
    @(negedge clk); rst_n = 1'b1;

    // R1/R6: each fetch and memory bit alone, timing 0
    for (int k = 0; k < 4; k++) step(1, 0, 4'(1) << k, 0, 0, 0, all_en, "R1");
    for (int k = 0; k < 6; k++) step(1, 0, 0, 6'(1) << k, 0, 0, all_en, "R1");
    step(1, 0, 4'b0100, 0, 0, 0, all_en, "R6");  // trigger 6
    // R2: disabled trigger
    step(1, 0, 4'b0001, 0, 0, 0, 10'h3FE, "R2");
    // R3: chained pair 0, one then both members
    step(1, 0, 4'b0001, 0, 0, 5'b00001, all_en, "R3");
    step(1, 0, 4'b0011, 0, 0, 5'b00001, all_en, "R3");
    // R3: chained fetch/store pair 3, both matching
    step(1, 0, 4'b0100, 6'b010000, 0, 5'b01000, all_en, "R3");
    // R4: chained pair 2 with differing timing
    step(1, 0, 0, 6'b001100, 10'b0000100000, 5'b00100, all_en, "R4");
    step(1, 0, 0, 0, 0, 0, all_en, "R4");
    // R5: store/store chain bit ignored
    step(1, 0, 0, 6'b000001, 0, 5'b00010, all_en, "R5");
    // R7: timing-1 fire then delivery, then clear
    step(1, 0, 0, 6'b000100, 10'b0000010000, 0, all_en, "R7");
    step(1, 0, 0, 0, 0, 0, all_en, "R7");
    step(1, 0, 0, 0, 0, 0, all_en, "R7");
    // R12: pending held across idle cycles
    step(1, 0, 4'b1000, 0, 10'b0100000000, 0, all_en, "R12");
    step(0, 0, 0, 0, 0, 0, all_en, "R12");
    step(0, 0, 4'b0001, 0, 0, 0, all_en, "R12");
    step(1, 0, 0, 0, 0, 0, all_en, "R12");
    // R8: flush drops pending
    step(1, 0, 4'b0010, 0, 10'b0000000010, 0, all_en, "R8");
    step(1, 1, 4'b0001, 0, 0, 0, all_en, "R8");
    step(1, 0, 0, 0, 0, 0, all_en, "R8");
    // R9: coincidence of timing-0 fire with pending trap
    step(1, 0, 0, 6'b100000, 10'b1000000000, 0, all_en, "R9");
    step(1, 0, 0, 6'b000010, 0, 0, all_en, "R9");
    step(1, 0, 0, 0, 0, 0, all_en, "R9");
    // R10: several sources, lowest index recorded
    step(1, 0, 4'b1100, 6'b110000, 0, 0, all_en, "R10");

    // Random mix against the model
    void'($urandom(32'd20240611));
    for (int i = 0; i < 600; i++) begin
      logic v, f;
      v = ($urandom % 4) != 0;
      f = ($urandom % 16) == 0;
      step(v, f, 4'($urandom), 6'($urandom), 10'($urandom), 5'($urandom),
           10'($urandom) | 10'($urandom), "R2");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule